// File: doc/BRIEF.md
# PCIe Root-Port Client Interrupt Aggregator

This block collects sixteen event lines from a PCIe root-port client and presents them to software through two 32-bit registers on a simple register bus. An event pulse or level on any input sets the matching status bit, which then holds until software clears it. Software clears bits by writing ones to them, so writing back the value just read clears exactly the events it saw. A second register masks individual events. Each write to it carries its own per-bit write enables in the upper half word, so software can change one mask bit without reading the register first.

Unmasked pending events drive three interrupt outputs. Events 0 to 4 drive a system output: power state change, hot plug, PHY, DMA, and the local core summary. The four legacy INTx lines in bits 8:5 drive a separate legacy output, together with the 1-based index of the lowest pending line. Events 9 to 15 drive a client output: the error classes, DPA, hot reset, message done and legacy done. All four outputs are registered.

Top module: `evtirq_ctrl`

## Requirements
- R1: After reset, status reads 0x0000, mask reads 0xFFFF, and all interrupt outputs and the index are 0.
- R2: A 1 on `evt_in[k]` at a clock edge sets status bit k. The bit stays set after the input returns to 0, until it is cleared.
- R3: A write to the status register (offset 0x50) clears every status bit whose `bus_wdata` bit in 15:0 is 1 and leaves the others unchanged. Bits 31:16 of the write have no effect.
- R4: If an event on bit k and a clearing write of bit k occur in the same cycle, bit k ends up set.
- R5: A write to the mask register (offset 0x4C) sets mask bit k to `bus_wdata[k]` only when `bus_wdata[16+k]` is 1. Otherwise mask bit k keeps its value.
- R6: A mask bit of 1 keeps its status bit from affecting any output. The status bit is still latched and readable.
- R7: `sys_irq` is 1 when any of status bits 4:0 is set and unmasked.
- R8: `intx_irq` is 1 when any of status bits 8:5 (INTA to INTD) is set and unmasked. `intx_idx` gives the position of the lowest such bit: 1 for bit 5 up to 4 for bit 8, and 0 when none is pending.
- R9: `client_irq` is 1 when any of status bits 15:9 is set and unmasked.
- R10: The outputs reflect the status and mask values that hold before a clock edge and appear after that edge. They lag a status or mask change by exactly one cycle.
- R11: Reads return the status or mask value in bits 15:0 with zeros above. Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 16 | Raw event lines, sampled every edge |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sys_irq | output | 1 | Summary of events 4:0 |
| intx_irq | output | 1 | Summary of legacy INTx events 8:5 |
| intx_idx | output | 3 | 1-based lowest pending INTx line, 0 if none |
| client_irq | output | 1 | Summary of events 15:9 |

## Verification
The bench targets an event that arrives in the same cycle as a clearing write of that bit. A design where the clear wins would lose an interrupt, and the status read would show a 0. Mask writes with partial enables would expose a design that ignores the enable half: untouched mask bits would flip, and outputs would fire or go silent unexpectedly. INTx patterns with several lines pending check that the index reports the lowest line and returns to 0, and one-cycle output latency checks catch outputs that are combinational or delayed twice. Writes to unused offsets would show up as corrupted status or mask if the address decode were incomplete.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

    localparam int EVT_W   = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h50;

    localparam int SYS_LO = 0;
    localparam int SYS_HI = 4;
    localparam int LEG_LO = 5;
    localparam int LEG_HI = 8;
    localparam int CLI_LO = 9;
    localparam int CLI_HI = 15;

    localparam int LEG_N = LEG_HI - LEG_LO + 1;
    localparam int IDX_W = $clog2(LEG_N + 1);

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             sys;
        logic             leg;
        logic             cli;
        logic [IDX_W-1:0] idx;
    } irq_out_t;

    function automatic logic [IDX_W-1:0] lowest_line(input logic [LEG_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = LEG_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/evtirq_decode.sv
module evtirq_decode
    import evtirq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic              wr_mask,
    output logic              wr_stat
);
    always_comb begin
        case (bus_addr)
            OFS_MASK: sel = SEL_MASK;
            OFS_STAT: sel = SEL_STAT;
            default:  sel = SEL_NONE;
        endcase
    end

    assign wr_mask = bus_sel && bus_wr && (sel == SEL_MASK);
    assign wr_stat = bus_sel && bus_wr && (sel == SEL_STAT);
endmodule

// File: rtl/evtirq_status.sv
module evtirq_status #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] sts
);
    logic [W-1:0] clr_v;

    assign clr_v = clr_en ? clr_bits : '0;

    // New events take priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) sts <= '0;
        else     sts <= (sts & ~clr_v) | evt;
    end
endmodule

// File: rtl/evtirq_mask.sv
module evtirq_mask #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] wen,
    output logic [W-1:0] mask
);
    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)                 mask[k] <= 1'b1;
                else if (wr_en && wen[k]) mask[k] <= wval[k];
            end
        end
    endgenerate
endmodule

// File: rtl/evtirq_group.sv
module evtirq_group
    import evtirq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sts,
    input  logic [W-1:0] mask,
    output irq_out_t     outs
);
    logic [W-1:0] pend;
    irq_out_t     nxt;

    assign pend = sts & ~mask;

    always_comb begin
        nxt.sys = |pend[SYS_HI:SYS_LO];
        nxt.leg = |pend[LEG_HI:LEG_LO];
        nxt.cli = |pend[CLI_HI:CLI_LO];
        nxt.idx = lowest_line(pend[LEG_HI:LEG_LO]);
    end

    always_ff @(posedge clk) begin
        if (rst) outs <= '0;
        else     outs <= nxt;
    end
endmodule

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
    import evtirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_irq,
    output logic              intx_irq,
    output logic [IDX_W-1:0]  intx_idx,
    output logic              client_irq
);
    localparam int PAD_W = DATA_W - EVT_W;

    reg_sel_e         sel;
    logic             wr_mask;
    logic             wr_stat;
    logic [EVT_W-1:0] sts_q;
    logic [EVT_W-1:0] mask_q;
    irq_out_t         outs;

    evtirq_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .sel     (sel),
        .wr_mask (wr_mask),
        .wr_stat (wr_stat)
    );

    evtirq_status #(.W(EVT_W)) u_sts (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_in),
        .clr_en  (wr_stat),
        .clr_bits(bus_wdata[EVT_W-1:0]),
        .sts     (sts_q)
    );

    evtirq_mask #(.W(EVT_W)) u_msk (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_mask),
        .wval (bus_wdata[EVT_W-1:0]),
        .wen  (bus_wdata[2*EVT_W-1:EVT_W]),
        .mask (mask_q)
    );

    evtirq_group #(.W(EVT_W)) u_grp (
        .clk (clk),
        .rst (rst),
        .sts (sts_q),
        .mask(mask_q),
        .outs(outs)
    );

    always_comb begin
        case (sel)
            SEL_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
            SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, sts_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign sys_irq    = outs.sys;
    assign intx_irq   = outs.leg;
    assign intx_idx   = outs.idx;
    assign client_irq = outs.cli;
endmodule

// File: rtl/evtirq_chk.sv
module evtirq_chk
    import evtirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EVT_W-1:0]  evt_in,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [EVT_W-1:0]  sts_q,
    input logic [EVT_W-1:0]  mask_q,
    input logic              sys_irq,
    input logic              intx_irq,
    input logic [IDX_W-1:0]  intx_idx,
    input logic              client_irq
);
    logic stat_wr, mask_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    assign mask_wr = bus_sel && bus_wr && (bus_addr == OFS_MASK);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((sts_q & $past(evt_in)) == $past(evt_in))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((sts_q & $past(bus_wdata[EVT_W-1:0] & ~evt_in)) == '0)); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q)); // R5

    AST_MASK_ENABLED: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> ((mask_q & $past(bus_wdata[2*EVT_W-1:EVT_W])) ==
                     $past(bus_wdata[EVT_W-1:0] & bus_wdata[2*EVT_W-1:EVT_W]))); // R5

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |=> (!sys_irq && !intx_irq && !client_irq)); // R6

    AST_SYS_LAG: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sys_irq == $past(|(sts_q[SYS_HI:SYS_LO] & ~mask_q[SYS_HI:SYS_LO])))); // R10

    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        (intx_idx <= IDX_W'(LEG_N)) && ((intx_idx != '0) == intx_irq)); // R8
endmodule

bind evtirq_ctrl evtirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_in    (evt_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sts_q     (sts_q),
    .mask_q    (mask_q),
    .sys_irq   (sys_irq),
    .intx_irq  (intx_irq),
    .intx_idx  (intx_idx),
    .client_irq(client_irq)
);

// File: tb/sim_evtirq_ctrl.sv
`timescale 1ns/1ps
module sim_evtirq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt = '0;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_irq, intx_irq, client_irq;
    logic [2:0]  intx_idx;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_sts, m_msk;
    logic [5:0]  exp_out;

    localparam logic [7:0] A_MSK = 8'h4C;
    localparam logic [7:0] A_STS = 8'h50;

    always #10 clk = ~clk;

    evtirq_ctrl u0 (
        .clk(clk), .rst(rst), .evt_in(evt), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .sys_irq(sys_irq), .intx_irq(intx_irq), .intx_idx(intx_idx),
        .client_irq(client_irq)
    );

    function automatic logic [5:0] outs_of(input logic [15:0] s, input logic [15:0] m);
        logic [15:0] p;
        logic [2:0]  ix;
        p  = s & ~m;
        ix = 3'd0;
        for (int i = 3; i >= 0; i--) if (p[5+i]) ix = 3'(i + 1);
        return {|p[4:0], |p[8:5], |p[15:9], ix};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk(tag, {26'd0, sys_irq, intx_irq, client_irq, intx_idx}, {26'd0, exp_out});
    endtask

    // Drive one cycle from a negedge; model the edge; end at next negedge
    task automatic cyc(input logic [15:0] e, input logic s, input logic w,
                       input logic [7:0] a, input logic [31:0] d);
        evt = e; sel = s; wr = w; addr = a; wdata = d;
        @(posedge clk);
        exp_out = outs_of(m_sts, m_msk);
        if (s && w && a == A_STS) m_sts = m_sts & ~d[15:0];
        m_sts = m_sts | e;
        if (s && w && a == A_MSK) m_msk = (m_msk & ~d[31:16]) | (d[15:0] & d[31:16]);
        @(negedge clk);
        evt = '0; sel = 1'b0; wr = 1'b0;
        chk_outs("R7/R8/R9/R10 outputs");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(tag, rdata, exp);
        sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_sts = '0; m_msk = '1; exp_out = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(A_STS, 32'h0, "R1 status after reset");
        rd(A_MSK, 32'h0000FFFF, "R1 mask after reset");
        chk("R1 outputs after reset", {26'd0, sys_irq, intx_irq, client_irq, intx_idx}, 32'h0);

        // R2 latch, R6 masked bit still latched, no output
        cyc(16'h0001, 0, 0, 0, 0);
        cyc(16'h0000, 0, 0, 0, 0);
        rd(A_STS, 32'h1, "R2 event latched after input dropped");
        chk("R6 masked event gives no sys_irq", {31'd0, sys_irq}, 32'h0);

        // R5 partial enable: unmask bit 0 only
        cyc(16'h0, 1, 1, A_MSK, 32'h0001_0000);
        rd(A_MSK, 32'h0000FFFE, "R5 only enabled mask bit changed");
        // R10: sys rises one cycle after mask change
        chk("R10 sys not yet raised", {31'd0, sys_irq}, 32'h0);
        cyc(16'h0, 0, 0, 0, 0);
        chk("R7 sys raised by unmasked bit 0", {31'd0, sys_irq}, 32'h1);

        // R5 write with no enables changes nothing
        cyc(16'h0, 1, 1, A_MSK, 32'h0000_FFFF);
        rd(A_MSK, 32'h0000FFFE, "R5 no enables no change");

        // unmask everything
        cyc(16'h0, 1, 1, A_MSK, 32'hFFFF_0000);
        rd(A_MSK, 32'h0, "R5 full unmask");

        // R3 W1C exact, upper bits ignored
        cyc(16'hA5F0, 0, 0, 0, 0);
        cyc(16'h0, 1, 1, A_STS, 32'hFFFF_0011);
        rd(A_STS, 32'h0000A5E1 & ~32'h11 | 32'h1 & 32'h0, "R3 exact bits cleared");
        // status now 0xA5E0 (bit0 cleared, bit4 cleared)
        cyc(16'h0, 0, 0, 0, 0);

        // R8 index: bits 5..8 present -> lowest is bit5 -> 1
        chk("R8 intx index lowest line", {29'd0, intx_idx}, 32'd1);
        cyc(16'h0, 1, 1, A_STS, 32'h0000_0060);
        cyc(16'h0, 0, 0, 0, 0);
        chk("R8 index after clearing lines 1,2", {29'd0, intx_idx}, 32'd3);
        cyc(16'h0, 1, 1, A_STS, 32'h0000_0180);
        cyc(16'h0, 0, 0, 0, 0);
        chk("R8 no INTx pending index 0", {28'd0, intx_irq, intx_idx}, 32'd0);
        chk("R9 client still pending", {31'd0, client_irq}, 32'h1);

        // R4 set wins over same-cycle clear
        cyc(16'h0200, 1, 1, A_STS, 32'h0000_FFFF);
        rd(A_STS, 32'h0200, "R4 set wins against clear");

        // R11 unused offset: read 0, write ignored
        rd(8'h48, 32'h0, "R11 unused offset reads zero");
        cyc(16'h0, 1, 1, 8'h48, 32'hFFFF_FFFF);
        rd(A_STS, 32'h0200, "R11 status untouched by stray write");
        rd(A_MSK, 32'h0, "R11 mask untouched by stray write");

        // random phase
        for (int t = 0; t < 400; t++) begin
            logic [15:0] e;
            logic [31:0] d;
            int k;
            e = 16'($urandom & $urandom & $urandom);
            d = $urandom;
            k = $urandom_range(0, 4);
            case (k)
                0: cyc(e, 1, 1, A_STS, d);
                1: cyc(e, 1, 1, A_MSK, d);
                2: cyc(e, 1, 1, 8'($urandom), d);
                default: cyc(e, 0, 0, 0, 0);
            endcase
            rd(A_STS, {16'd0, m_sts}, "R2/R3/R4 random status");
            rd(A_MSK, {16'd0, m_msk}, "R5/R11 random mask");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule